// File: doc/BRIEF.md
# Serial Link Training Controller

This block brings one end of a point-to-point serial link from reset to an operational state. It waits for a far-end partner, runs a polling phase until the receive path is locked, then runs an ordered handshake of training tokens: TS1 first, then TS2. That handshake settles the lane width and the data rate, and the link is then marked up. When the link fails, a retrain path repeats the handshake and returns to the operational state. If the handshake cannot finish in time, training restarts from the beginning.

The partner is seen through a symbolic token channel. Each cycle carries no token, TS1 or TS2 in each direction, together with the lane count that the partner advertises. Every training state has its own timeout limit, set by a parameter, so the controller never waits forever. Outputs give the encoded state, a link-up flag, the agreed width as a one-hot vector and the agreed rate.

Top module: `lnk_train_ctrl`

## Requirements
- R1: After rst_n low or a cycle with hot_reset_i high, the next sampled outputs are state 0 (detect), link_up_o 0, width_o 0, rate_o 0 and tx_token_o 0. hot_reset_i has priority over every other input.
- R2: In detect, the controller moves to polling (state 1) on the first edge where partner_present_i is high. Without a partner it stays in detect for any length of time.
- R3: In polling the controller sends TS1 (tx_token_o = 1). It moves to configuration (state 2) only on an edge where bit_lock_i, sym_lock_i and polarity_set_i are all high.
- R4: Token codes are 0 = none, 1 = TS1, 2 = TS2, in both directions. In configuration and recovery the controller first sends TS1. It starts sending TS2 only after it receives TS1. It completes only when it receives TS2 while sending TS2. A TS2 received while the controller is still sending TS1 is ignored.
- R5: When configuration completes, width_o becomes the largest of x1, x2, x4 and x8 that does not exceed the smaller of LOCAL_MAX_LANES and partner_lanes_i. It is encoded one-hot as bit0 = x1, bit1 = x2, bit2 = x4, bit3 = x8. An advertised count of 0 gives x1.
- R6: State codes are detect 0, polling 1, configuration 2, operational 3, recovery 4. link_up_o is high exactly while the state is 3.
- R7: When configuration completes, rate_o takes the value of rate_req_i (1 = Gen1 2.5 GT/s, 2 = Gen2 5.0 GT/s, 3 = Gen3 8.0 GT/s). A request of 0 gives Gen1. rate_o then stays fixed through the operational and recovery states whatever rate_req_i does. It is 0 while the link is untrained.
- R8: link_fail_i in the operational state moves to recovery (state 4) on the next edge, with width_o and rate_o kept. A completed TS1/TS2 exchange returns to state 3 with the same width and rate.
- R9: Polling, configuration and recovery each leave for detect after POLL_TO, CFG_TO or REC_TO cycles respectively, counting from the first sampled cycle in the state. The state is still shown on the cycle at which the count equals the limit, and the controller is in detect one cycle later. Leaving for detect clears width_o and rate_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_reset_i | input | 1 | Synchronous restart into detect |
| partner_present_i | input | 1 | Far-end partner sensed |
| bit_lock_i | input | 1 | Receive bit lock achieved |
| sym_lock_i | input | 1 | Receive symbol lock achieved |
| polarity_set_i | input | 1 | Lane polarity resolved |
| rx_token_i | input | 2 | Token from partner: 0 none, 1 TS1, 2 TS2 |
| partner_lanes_i | input | 4 | Lane count advertised by partner |
| rate_req_i | input | 2 | Requested rate code |
| link_fail_i | input | 1 | Link failure seen in operational state |
| tx_token_o | output | 2 | Token sent to partner |
| state_o | output | 5 | Encoded training state |
| link_up_o | output | 1 | Link operational |
| width_o | output | 4 | One-hot negotiated width |
| rate_o | output | 2 | Negotiated rate code |

## Verification
The properties take rst_n and hot_reset_i as the only ways to restart the controller. They treat every other input as free to change at any cycle, with no ordering promise from the partner. The bench drives all inputs on the falling edge and holds them for whole cycles. It sends tokens out of order, holds locks partly asserted and lets timers expire, so the guarded conditions are reached from inside the allowed input space. Each scenario starts from a hot reset, so the properties never see a restart from an undefined state.

// File: rtl/lnk_train_pkg.sv
package lnk_train_pkg;

    typedef enum logic [4:0] {
        ST_DETECT = 5'd0,
        ST_POLL   = 5'd1,
        ST_CFG    = 5'd2,
        ST_L0     = 5'd3,
        ST_RECOV  = 5'd4
    } lnk_state_e;

    typedef enum logic [1:0] {
        TOK_NONE = 2'd0,
        TOK_TS1  = 2'd1,
        TOK_TS2  = 2'd2
    } lnk_tok_e;

    localparam int NUM_WIDTHS = 4;   // x1, x2, x4, x8
    localparam int LANE_CNT_W = 4;

    typedef struct packed {
        lnk_state_e            state;
        logic                  phase;   // 0: sending TS1, 1: sending TS2
        logic [NUM_WIDTHS-1:0] width;
        logic [1:0]            rate;
    } lnk_regs_t;

endpackage

// File: rtl/lnk_state_timer.sv
module lnk_state_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = '0;
        else if (cnt_q != limit_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == limit_i);

    // R9: the count never passes the limit of the current state unless the state changed
    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && $stable(limit_i) && cnt_q <= limit_i) |=> (cnt_q <= limit_i));

endmodule

// File: rtl/lnk_width_pick.sv
module lnk_width_pick
    import lnk_train_pkg::*;
#(
    parameter int LOCAL_MAX_LANES = 8
) (
    input  logic [LANE_CNT_W-1:0] partner_lanes_i,
    output logic [NUM_WIDTHS-1:0] width_oh_o
);
    int limit;

    always_comb begin
        limit = int'(partner_lanes_i);
        if (limit > LOCAL_MAX_LANES) limit = LOCAL_MAX_LANES;
        width_oh_o = NUM_WIDTHS'(1);
        for (int i = 1; i < NUM_WIDTHS; i++) begin
            if (limit >= (1 << i)) width_oh_o = NUM_WIDTHS'(1) << i;
        end
    end

endmodule

// File: rtl/lnk_train_ctrl.sv
module lnk_train_ctrl
    import lnk_train_pkg::*;
#(
    parameter int LOCAL_MAX_LANES = 8,
    parameter int CNT_W           = 16,
    parameter int DETECT_TO       = 1000,
    parameter int POLL_TO         = 400,
    parameter int CFG_TO          = 300,
    parameter int REC_TO          = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot_reset_i,
    input  logic       partner_present_i,
    input  logic       bit_lock_i,
    input  logic       sym_lock_i,
    input  logic       polarity_set_i,
    input  logic [1:0] rx_token_i,
    input  logic [3:0] partner_lanes_i,
    input  logic [1:0] rate_req_i,
    input  logic       link_fail_i,
    output logic [1:0] tx_token_o,
    output logic [4:0] state_o,
    output logic       link_up_o,
    output logic [3:0] width_o,
    output logic [1:0] rate_o
);
    lnk_regs_t r_d, r_q;

    logic             tmr_restart;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic [3:0]       pick_width;
    logic [1:0]       pick_rate;
    logic             locks_ok;

    lnk_width_pick #(.LOCAL_MAX_LANES(LOCAL_MAX_LANES)) u_pick (
        .partner_lanes_i (partner_lanes_i),
        .width_oh_o      (pick_width)
    );

    lnk_state_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .limit_i   (tmr_limit),
        .expire_o  (tmr_expire)
    );

    assign locks_ok  = bit_lock_i && sym_lock_i && polarity_set_i;
    assign pick_rate = (rate_req_i == 2'd0) ? 2'd1 : rate_req_i;

    always_comb begin
        case (r_q.state)
            ST_POLL:  tmr_limit = CNT_W'(POLL_TO);
            ST_CFG:   tmr_limit = CNT_W'(CFG_TO);
            ST_RECOV: tmr_limit = CNT_W'(REC_TO);
            default:  tmr_limit = CNT_W'(DETECT_TO);
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_DETECT: begin
                if (partner_present_i) r_d.state = ST_POLL;
            end
            ST_POLL: begin
                if (locks_ok) begin
                    r_d.state = ST_CFG;
                    r_d.phase = 1'b0;
                end else if (tmr_expire) begin
                    r_d.state = ST_DETECT;
                end
            end
            ST_CFG, ST_RECOV: begin
                if (!r_q.phase && rx_token_i == TOK_TS1) begin
                    r_d.phase = 1'b1;
                end else if (r_q.phase && rx_token_i == TOK_TS2) begin
                    r_d.state = ST_L0;
                    r_d.phase = 1'b0;
                    if (r_q.state == ST_CFG) begin
                        r_d.width = pick_width;
                        r_d.rate  = pick_rate;
                    end
                end else if (tmr_expire) begin
                    r_d.state = ST_DETECT;
                end
            end
            ST_L0: begin
                if (link_fail_i) begin
                    r_d.state = ST_RECOV;
                    r_d.phase = 1'b0;
                end
            end
            default: r_d.state = ST_DETECT;
        endcase
        if (hot_reset_i) r_d.state = ST_DETECT;
        if (r_d.state == ST_DETECT) begin
            r_d.phase = 1'b0;
            r_d.width = '0;
            r_d.rate  = '0;
        end
    end

    assign tmr_restart = (r_d.state != r_q.state) || tmr_expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_DETECT, phase: 1'b0, width: '0, rate: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.state)
            ST_POLL:          tx_token_o = TOK_TS1;
            ST_CFG, ST_RECOV: tx_token_o = r_q.phase ? TOK_TS2 : TOK_TS1;
            default:          tx_token_o = TOK_NONE;
        endcase
    end

    assign state_o   = r_q.state;
    assign link_up_o = (r_q.state == ST_L0);
    assign width_o   = r_q.width;
    assign rate_o    = r_q.rate;

    // R1: hot reset always lands in detect
    a_r1_hot_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hot_reset_i |=> (state_o == ST_DETECT && !link_up_o));

    // R3: polling never advances without full lock and polarity
    a_r3_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_POLL && !locks_ok) |=> (state_o != ST_CFG));

    // R4: no completion while still sending TS1
    a_r4_ts2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_CFG && tx_token_o == TOK_TS1) |=> (state_o != ST_L0));

    // R5, R6: an operational link always carries a one-hot width and a rate
    a_r6_up_has_width: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> ($onehot(width_o) && rate_o != 2'd0));

    // R7: rate fixed while trained
    a_r7_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_o && !hot_reset_i) |=> $stable(rate_o));

    // R8: recovery keeps the width unless it gives up
    a_r8_recov_keeps_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RECOV && !hot_reset_i && !tmr_expire) |=> $stable(width_o));

    // R9: polling timeout falls back to detect
    a_r9_poll_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_POLL && tmr_expire && !locks_ok) |=> (state_o == ST_DETECT));

endmodule

// File: tb/lnk_train_ctrl_test.sv
module lnk_train_ctrl_test;
    localparam int P_DET = 50;
    localparam int P_POLL = 20;
    localparam int P_CFG = 24;
    localparam int P_REC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hot_reset_i = 1'b0;
    logic       partner_present_i = 1'b0;
    logic       bit_lock_i = 1'b0;
    logic       sym_lock_i = 1'b0;
    logic       polarity_set_i = 1'b0;
    logic [1:0] rx_token_i = 2'd0;
    logic [3:0] partner_lanes_i = 4'd0;
    logic [1:0] rate_req_i = 2'd0;
    logic       link_fail_i = 1'b0;
    logic [1:0] tx_token_o;
    logic [4:0] state_o;
    logic       link_up_o;
    logic [3:0] width_o;
    logic [1:0] rate_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lnk_train_ctrl #(
        .LOCAL_MAX_LANES(8), .CNT_W(8), .DETECT_TO(P_DET),
        .POLL_TO(P_POLL), .CFG_TO(P_CFG), .REC_TO(P_REC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hot_reset_i(hot_reset_i),
        .partner_present_i(partner_present_i), .bit_lock_i(bit_lock_i),
        .sym_lock_i(sym_lock_i), .polarity_set_i(polarity_set_i),
        .rx_token_i(rx_token_i), .partner_lanes_i(partner_lanes_i),
        .rate_req_i(rate_req_i), .link_fail_i(link_fail_i),
        .tx_token_o(tx_token_o), .state_o(state_o), .link_up_o(link_up_o),
        .width_o(width_o), .rate_o(rate_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic restart();
        hot_reset_i = 1'b1;
        partner_present_i = 1'b0;
        {bit_lock_i, sym_lock_i, polarity_set_i} = 3'b000;
        rx_token_i = 2'd0;
        link_fail_i = 1'b0;
        tick();
        hot_reset_i = 1'b0;
    endtask

    task automatic bring_up(input logic [3:0] lanes, input logic [1:0] rq);
        restart();
        partner_present_i = 1'b1;
        {bit_lock_i, sym_lock_i, polarity_set_i} = 3'b111;
        tick();
        tick();
        rx_token_i = 2'd1;
        tick();
        rx_token_i = 2'd2;
        partner_lanes_i = lanes;
        rate_req_i = rq;
        tick();
        rx_token_i = 2'd0;
    endtask

    task automatic t_reset_state();
        chk("R1 state", state_o, 0);
        chk("R1 link_up", link_up_o, 0);
        chk("R1 width", width_o, 0);
        chk("R1 rate", rate_o, 0);
        chk("R1 tx", tx_token_o, 0);
    endtask

    task automatic t_detect_and_poll();
        restart();
        repeat (P_DET + 10) tick();
        chk("R2 stays detect", state_o, 0);
        partner_present_i = 1'b1;
        {bit_lock_i, sym_lock_i, polarity_set_i} = 3'b110;
        tick();
        chk("R2 to polling", state_o, 1);
        chk("R3 polling sends TS1", tx_token_o, 1);
        repeat (3) tick();
        chk("R3 no polarity holds polling", state_o, 1);
        polarity_set_i = 1'b1;
        tick();
        chk("R3 to configuration", state_o, 2);
        chk("R4 cfg sends TS1", tx_token_o, 1);
        rx_token_i = 2'd2;
        repeat (2) tick();
        chk("R4 early TS2 ignored state", state_o, 2);
        chk("R4 early TS2 ignored tx", tx_token_o, 1);
        rx_token_i = 2'd1;
        tick();
        chk("R4 TS2 after TS1", tx_token_o, 2);
        rx_token_i = 2'd2;
        partner_lanes_i = 4'd6;
        rate_req_i = 2'd2;
        tick();
        rx_token_i = 2'd0;
        chk("R6 state L0", state_o, 3);
        chk("R6 link_up", link_up_o, 1);
        chk("R5 width x4 from 6", width_o, 4'b0100);
        chk("R7 rate Gen2", rate_o, 2);
    endtask

    task automatic t_widths();
        bring_up(4'd8, 2'd3);  chk("R5 width x8", width_o, 4'b1000);
        chk("R7 rate Gen3", rate_o, 3);
        bring_up(4'd15, 2'd1); chk("R5 local cap x8", width_o, 4'b1000);
        bring_up(4'd3, 2'd1);  chk("R5 width x2 from 3", width_o, 4'b0010);
        bring_up(4'd1, 2'd1);  chk("R5 width x1", width_o, 4'b0001);
        bring_up(4'd0, 2'd0);  chk("R5 zero gives x1", width_o, 4'b0001);
        chk("R7 zero request Gen1", rate_o, 1);
    endtask

    task automatic t_rate_fixed_and_recovery();
        bring_up(4'd4, 2'd2);
        rate_req_i = 2'd3;
        partner_lanes_i = 4'd1;
        repeat (4) tick();
        chk("R7 rate fixed in L0", rate_o, 2);
        link_fail_i = 1'b1;
        tick();
        link_fail_i = 1'b0;
        chk("R8 to recovery", state_o, 4);
        chk("R6 link down in recovery", link_up_o, 0);
        chk("R8 width kept", width_o, 4'b0100);
        rx_token_i = 2'd2;
        tick();
        chk("R4 recovery ignores early TS2", state_o, 4);
        rx_token_i = 2'd1;
        tick();
        rx_token_i = 2'd2;
        tick();
        rx_token_i = 2'd0;
        chk("R8 back to L0", state_o, 3);
        chk("R8 width same", width_o, 4'b0100);
        chk("R8 rate same", rate_o, 2);
        link_fail_i = 1'b1;
        tick();
        link_fail_i = 1'b0;
        repeat (P_REC) tick();
        chk("R9 recovery at limit", state_o, 4);
        tick();
        chk("R9 recovery timeout detect", state_o, 0);
        chk("R9 width cleared", width_o, 0);
        chk("R9 rate cleared", rate_o, 0);
    endtask

    task automatic t_timeouts();
        restart();
        partner_present_i = 1'b1;
        tick();
        partner_present_i = 1'b0;
        repeat (P_POLL) tick();
        chk("R9 polling at limit", state_o, 1);
        tick();
        chk("R9 polling timeout", state_o, 0);
        restart();
        partner_present_i = 1'b1;
        {bit_lock_i, sym_lock_i, polarity_set_i} = 3'b111;
        tick();
        tick();
        partner_present_i = 1'b0;
        chk("R3 cfg entered", state_o, 2);
        repeat (P_CFG) tick();
        chk("R9 cfg at limit", state_o, 2);
        tick();
        chk("R9 cfg timeout", state_o, 0);
    endtask

    task automatic t_hot_reset();
        bring_up(4'd2, 2'd1);
        chk("R5 width x2", width_o, 4'b0010);
        hot_reset_i = 1'b1;
        link_fail_i = 1'b1;
        tick();
        hot_reset_i = 1'b0;
        link_fail_i = 1'b0;
        t_reset_state();
    endtask

    initial begin
        repeat (3) tick();
        t_reset_state();
        rst_n = 1'b1;
        tick();
        t_detect_and_poll();
        t_widths();
        t_rate_fixed_and_recovery();
        t_timeouts();
        t_hot_reset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule